// File: doc/BRIEF.md
# Half-Duplex Three-Wire Serial Master with Bus Turnaround

This block is a serial-bus master that uses one shared data wire for both directions. It drives the serial clock and an active-low chip select. It also drives the shared wire through a separate output-enable pin, which the pad ring turns into a tristate buffer. A transaction is opened by a one-cycle `start` pulse. It sends a programmed number of command bytes and then releases the wire for a programmed number of turnaround clock pulses. After that it reads back a programmed number of response bytes. Chip select stays low for the whole transaction.

Outgoing bytes come in through a valid/ready handshake. Incoming bytes go out through a second valid/ready handshake. While the block waits on either handshake, the serial clock stays low. The bit timing is clock-idle-low. The block changes the data on the falling edge of the serial clock, and both sides sample on the rising edge. Each byte can be sent most-significant bit first or least-significant bit first. The serial clock period is two half-periods, and the length of each half-period in system clocks is programmable.

Top module: `spi3w_master`

## Requirements
- R1: After reset, and whenever no transaction is active (`busy` low), `csN` is 1, `sclk` is 0 and `sdoEn` is 1.
- R2: `csN` goes low when a transaction starts and returns high only after the last clock pulse. Every rising edge of `sclk` falls inside the `csN`-low window.
- R3: `sclk` idles low. `sdo` never changes while `sclk` is high, so each bit is set up before the rising edge on which it is sampled.
- R4: `wrBytes` command bytes are shifted out on `sdo` in the order they are accepted. With `lsbFirst`=1 bit 0 goes first; with `lsbFirst`=0 bit 7 goes first.
- R5: After the last command bit, exactly S turnaround pulses occur on `sclk` before the first read bit is sampled, where S is `swapCycles`. So the transaction has 8*`wrBytes` + S + 8*`rdBytes` rising edges in total.
- R6: A `swapCycles` value of 0 gives one turnaround pulse.
- R7: Response bits are sampled from `sdi` on rising `sclk` edges and assembled in the order set by `lsbFirst`. Each byte is presented on `rxData` with `rxValid` high, and both are held unchanged until `rxReady` is seen.
- R8: `sdoEn` falls together with the falling edge after the last command bit. It stays low at every turnaround and read edge, and it rises again only while `csN` is high.
- R9: With `wrBytes`=0 the transaction begins directly with the turnaround pulses, and `sdoEn` is low from the first edge.
- R10: Every high phase of `sclk` lasts H system clocks, where H is `halfPeriod`, and a value of 0 gives H=1.
- R11: `txReady` is high only while the master waits for a command byte. In that state `sclk` is low and `csN` is low, and the clock does not run until `txValid` arrives.
- R12: The configuration inputs are captured on the accepted `start`. Changes to those inputs, and further `start` pulses while `busy` is high, do not affect the transaction and do not start a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transaction (taken only when idle) |
| wrBytes | input | CNT_W | Number of command bytes to send |
| rdBytes | input | CNT_W | Number of response bytes to read |
| swapCycles | input | SWAP_W | Turnaround clock pulses (0 means 1) |
| halfPeriod | input | DIV_W | System clocks per half serial-clock period (0 means 1) |
| lsbFirst | input | 1 | 1: bit 0 first, 0: bit 7 first |
| busy | output | 1 | High from the accepted start until the block is idle again |
| txData | input | DATA_W | Command byte |
| txValid | input | 1 | Command byte available |
| txReady | output | 1 | Master is waiting for a command byte |
| rxData | output | DATA_W | Received response byte |
| rxValid | output | 1 | Response byte available |
| rxReady | input | 1 | Consumer takes the response byte |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| sdo | output | 1 | Value driven onto the shared data wire |
| sdoEn | output | 1 | Output enable for the shared data wire |
| sdi | input | 1 | Value read back from the shared data wire |

## Verification
The clock starts H system clocks after a command byte is accepted. Each rising edge moves `sclk` one system clock after the half-period counter expires. `sdi` is sampled on the same system-clock edge at which `sclk` rises. `rxValid` rises on the edge that ends the last high phase of a byte, and it falls on the edge that sees `rxReady`. The bench changes all of its inputs on the falling edge of the system clock and reads results there, half a cycle after the registers settle. It records line values, `sdoEn` and `csN` at each rising edge of `sclk` itself, and its slave model moves to the next bit only after that edge. So the expected stream is compared edge by edge rather than by absolute cycle numbers, and only high-phase lengths are compared in system-clock counts.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TXWAIT,
    ST_TXLO,
    ST_TXHI,
    ST_SWLO,
    ST_SWHI,
    ST_RXLO,
    ST_RXHI,
    ST_RXHOLD,
    ST_DONE
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgLatch;
    logic load;
    logic shiftTx;
    logic sampleRx;
  } dpStrobe_t;

endpackage

// File: rtl/spi3w_ctrl.sv
module spi3w_ctrl
  import spi3w_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int SWAP_W = 5,
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  wrBytes,
  input  logic [CNT_W-1:0]  rdBytes,
  input  logic [SWAP_W-1:0] swapCycles,
  input  logic [DIV_W-1:0]  halfPeriod,
  input  logic              txValid,
  input  logic              rxReady,
  output logic              busy,
  output logic              txReady,
  output logic              rxValid,
  output logic              sclk,
  output logic              csN,
  output logic              sdoEn,
  output dpStrobe_t         strobe
);

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  ctrlState_e state, nextState;
  logic [DIV_W-1:0]  divCnt, hpReg;
  logic [SWAP_W-1:0] swapLeft;
  logic [CNT_W-1:0]  wrLeft, rdLeft;
  logic [BIT_W-1:0]  bitCnt;
  logic halfDone, lastBit, bitClear;

  assign halfDone = (divCnt == hpReg - 1'b1);
  assign lastBit  = (bitCnt == LAST_BIT);
  assign bitClear = (state == ST_IDLE) || (state == ST_TXWAIT) ||
                    (state == ST_SWHI) || (state == ST_RXHOLD);

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE:
        if (start) begin
          strobe.cfgLatch = 1'b1;
          nextState = (wrBytes != '0) ? ST_TXWAIT : ST_SWLO;
        end
      ST_TXWAIT:
        if (txValid) begin
          strobe.load = 1'b1;
          nextState   = ST_TXLO;
        end
      ST_TXLO: if (halfDone) nextState = ST_TXHI;
      ST_TXHI:
        if (halfDone) begin
          if (lastBit) nextState = (wrLeft != '0) ? ST_TXWAIT : ST_SWLO;
          else begin
            strobe.shiftTx = 1'b1;
            nextState      = ST_TXLO;
          end
        end
      ST_SWLO: if (halfDone) nextState = ST_SWHI;
      ST_SWHI:
        if (halfDone) begin
          if (swapLeft > SWAP_W'(1)) nextState = ST_SWLO;
          else nextState = (rdLeft != '0) ? ST_RXLO : ST_DONE;
        end
      ST_RXLO:
        if (halfDone) begin
          strobe.sampleRx = 1'b1;
          nextState       = ST_RXHI;
        end
      ST_RXHI: if (halfDone) nextState = lastBit ? ST_RXHOLD : ST_RXLO;
      ST_RXHOLD: if (rxReady) nextState = (rdLeft != '0) ? ST_RXLO : ST_DONE;
      ST_DONE: if (halfDone) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      hpReg    <= DIV_W'(1);
      swapLeft <= SWAP_W'(1);
      wrLeft   <= '0;
      rdLeft   <= '0;
      bitCnt   <= '0;
    end else begin
      state  <= nextState;
      divCnt <= (nextState != state) ? '0 : divCnt + 1'b1;
      if (strobe.cfgLatch) begin
        hpReg    <= (halfPeriod == '0) ? DIV_W'(1) : halfPeriod;
        swapLeft <= (swapCycles == '0) ? SWAP_W'(1) : swapCycles;
        wrLeft   <= wrBytes;
        rdLeft   <= rdBytes;
      end
      if (strobe.load) wrLeft <= wrLeft - 1'b1;
      if (state == ST_SWHI && halfDone) swapLeft <= swapLeft - 1'b1;
      if (state == ST_RXHI && halfDone && lastBit) rdLeft <= rdLeft - 1'b1;
      if (bitClear) bitCnt <= '0;
      else if ((state == ST_TXHI || state == ST_RXHI) && halfDone)
        bitCnt <= bitCnt + 1'b1;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign txReady = (state == ST_TXWAIT);
  assign rxValid = (state == ST_RXHOLD);
  assign sclk    = (state == ST_TXHI) || (state == ST_SWHI) || (state == ST_RXHI);
  assign csN     = (state == ST_IDLE) || (state == ST_DONE);
  assign sdoEn   = (state == ST_IDLE) || (state == ST_TXWAIT) ||
                   (state == ST_TXLO) || (state == ST_TXHI);

endmodule

// File: rtl/spi3w_dp.sv
module spi3w_dp
  import spi3w_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              lsbFirst,
  input  logic [DATA_W-1:0] txData,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] rxData
);

  logic              lsbReg;
  logic [DATA_W-1:0] txShift, rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lsbReg  <= 1'b0;
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strobe.cfgLatch) lsbReg <= lsbFirst;
      if (strobe.load) txShift <= txData;
      else if (strobe.shiftTx)
        txShift <= lsbReg ? (txShift >> 1) : (txShift << 1);
      if (strobe.sampleRx)
        rxShift <= lsbReg ? {sdi, rxShift[DATA_W-1:1]} : {rxShift[DATA_W-2:0], sdi};
    end
  end

  assign sdo    = lsbReg ? txShift[0] : txShift[DATA_W-1];
  assign rxData = rxShift;

endmodule

// File: rtl/spi3w_master.sv
module spi3w_master
  import spi3w_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int SWAP_W = 5,
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  wrBytes,
  input  logic [CNT_W-1:0]  rdBytes,
  input  logic [SWAP_W-1:0] swapCycles,
  input  logic [DIV_W-1:0]  halfPeriod,
  input  logic              lsbFirst,
  output logic              busy,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  output logic              sclk,
  output logic              csN,
  output logic              sdo,
  output logic              sdoEn,
  input  logic              sdi
);

  dpStrobe_t strobe;

  spi3w_ctrl #(
    .CNT_W(CNT_W), .SWAP_W(SWAP_W), .DIV_W(DIV_W), .DATA_W(DATA_W)
  ) ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .wrBytes(wrBytes), .rdBytes(rdBytes),
    .swapCycles(swapCycles), .halfPeriod(halfPeriod),
    .txValid(txValid), .rxReady(rxReady),
    .busy(busy), .txReady(txReady), .rxValid(rxValid),
    .sclk(sclk), .csN(csN), .sdoEn(sdoEn), .strobe(strobe)
  );

  spi3w_dp #(.DATA_W(DATA_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lsbFirst(lsbFirst),
    .txData(txData), .sdi(sdi), .sdo(sdo), .rxData(rxData)
  );

endmodule

// File: rtl/spi3w_master_chk.sv
module spi3w_master_chk #(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic [DIV_W-1:0]  halfPeriod,
  input logic              sclk,
  input logic              csN,
  input logic              sdo,
  input logic              sdoEn,
  input logic              txReady,
  input logic              rxValid,
  input logic              rxReady,
  input logic [DATA_W-1:0] rxData
);

  logic [DIV_W-1:0] hpSeen;
  logic [DIV_W:0]   hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hpSeen <= DIV_W'(1);
      hiCnt  <= '0;
    end else begin
      if (start && !busy) hpSeen <= (halfPeriod == '0) ? DIV_W'(1) : halfPeriod;
      hiCnt <= sclk ? hiCnt + 1'b1 : '0;
    end
  end

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (csN && !sclk && sdoEn)); // R1

  AST_CLOCK_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN); // R2

  AST_SDO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk) && sdoEn) |-> $stable(sdo)); // R3

  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData))); // R7

  AST_OE_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdoEn) |-> csN); // R8

  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> (hiCnt == {1'b0, hpSeen})); // R10

  AST_TX_WAIT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> (!sclk && !csN)); // R11

endmodule

bind spi3w_master spi3w_master_chk #(.DIV_W(DIV_W), .DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .halfPeriod(halfPeriod),
  .sclk(sclk), .csN(csN), .sdo(sdo), .sdoEn(sdoEn), .txReady(txReady),
  .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData)
);

// File: tb/spi3w_master_test.sv
module spi3w_master_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] wrBytes = '0, rdBytes = '0;
  logic [4:0] swapCycles = '0;
  logic [7:0] halfPeriod = '0;
  logic       lsbFirst = 1'b0;
  logic       busy;
  logic [7:0] txData = '0;
  logic       txValid = 1'b0;
  logic       txReady;
  logic [7:0] rxData;
  logic       rxValid;
  logic       rxReady = 1'b0;
  logic       sclk, csN, sdo, sdoEn, sdi;

  int checks = 0, errors = 0;

  // bench-side slave model
  int   edgeCnt = 0, rdStart = 0, rdTotal = 0, hpExp = 1;
  logic capBit [0:511];
  logic capOe  [0:511];
  logic capCs  [0:511];
  logic rdStream [0:511];
  logic slaveDrv;
  logic [7:0] txBytes [0:15];
  logic [7:0] rxBytes [0:15];
  logic [7:0] gotBytes [0:15];
  int   gotCnt = 0, hiRun = 0, hpErr = 0, stallErr = 0, holdErr = 0;

  always #10 clk = ~clk;

  always @* begin
    if (edgeCnt >= rdStart && (edgeCnt - rdStart) < rdTotal)
      slaveDrv = rdStream[edgeCnt - rdStart];
    else
      slaveDrv = 1'b0;
  end
  assign sdi = sdoEn ? sdo : slaveDrv;

  always @(posedge sclk) begin
    if (edgeCnt < 512) begin
      capBit[edgeCnt] = sdi;
      capOe[edgeCnt]  = sdoEn;
      capCs[edgeCnt]  = csN;
    end
    edgeCnt = edgeCnt + 1;
  end

  always @(negedge clk) begin
    if (sclk) hiRun = hiRun + 1;
    else if (hiRun != 0) begin
      if (hiRun != hpExp) hpErr = hpErr + 1;
      hiRun = 0;
    end
  end

  spi3w_master uut (
    .clk(clk), .rstN(rstN), .start(start), .wrBytes(wrBytes), .rdBytes(rdBytes),
    .swapCycles(swapCycles), .halfPeriod(halfPeriod), .lsbFirst(lsbFirst),
    .busy(busy), .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .sclk(sclk), .csN(csN), .sdo(sdo), .sdoEn(sdoEn), .sdi(sdi)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // one full transaction with all port-level checks
  task automatic run_txn(input int wr, input int rd, input int sw, input int hp,
                         input bit lsb, input int txGap, input int rxGap,
                         input bit poke, input string tag);
    int swEff, bad, idleCnt;
    swEff = (sw == 0) ? 1 : sw;
    hpExp = (hp == 0) ? 1 : hp;
    for (int k = 0; k < 16; k++) begin
      txBytes[k] = 8'hB2 + 8'(k * 8'h37);
      rxBytes[k] = 8'h6A ^ 8'(k * 8'h5C);
    end
    for (int k = 0; k < rd; k++)
      for (int i = 0; i < 8; i++)
        rdStream[k*8+i] = lsb ? rxBytes[k][i] : rxBytes[k][7-i];
    rdStart = 8*wr + swEff;
    rdTotal = 8*rd;
    edgeCnt = 0; gotCnt = 0; hpErr = 0; stallErr = 0; holdErr = 0; hiRun = 0;

    @(negedge clk);
    wrBytes = 8'(wr); rdBytes = 8'(rd); swapCycles = 5'(sw);
    halfPeriod = 8'(hp); lsbFirst = lsb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R12: scramble configuration after the start was taken
    wrBytes = 8'd3; rdBytes = 8'd5; swapCycles = 5'd9; halfPeriod = 8'd2;
    lsbFirst = ~lsb;

    fork
      begin : feeder
        for (int k = 0; k < wr; k++) begin
          for (int g = 0; g < txGap; g++) begin
            @(negedge clk);
            if (txReady && sclk) stallErr++;
          end
          txData = txBytes[k];
          txValid = 1'b1;
          while (!txReady) @(negedge clk);
          @(negedge clk);
          txValid = 1'b0;
        end
      end
      begin : collector
        for (int k = 0; k < rd; k++) begin
          while (!rxValid) @(negedge clk);
          gotBytes[k] = rxData;
          for (int g = 0; g < rxGap; g++) begin
            @(negedge clk);
            if (!rxValid || rxData != gotBytes[k]) holdErr++;
          end
          rxReady = 1'b1;
          @(negedge clk);
          rxReady = 1'b0;
          gotCnt++;
        end
      end
      begin : poker
        if (poke) begin
          repeat (20) @(negedge clk);
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
    join

    while (busy) @(negedge clk);

    check(edgeCnt == 8*wr + swEff + 8*rd, "R5", {tag, " rising edge total"},
          edgeCnt, 8*wr + swEff + 8*rd);
    for (int k = 0; k < wr; k++) begin
      logic [7:0] got;
      for (int i = 0; i < 8; i++)
        if (lsb) got[i] = capBit[k*8+i]; else got[7-i] = capBit[k*8+i];
      check(got == txBytes[k], "R4", {tag, " command byte"}, got, txBytes[k]);
    end
    bad = 0;
    for (int e = 0; e < edgeCnt && e < 512; e++)
      if (capOe[e] != (e < 8*wr)) bad++;
    check(bad == 0, "R8", {tag, " output-enable per edge mismatches"}, bad, 0);
    bad = 0;
    for (int e = 0; e < edgeCnt && e < 512; e++)
      if (capCs[e] != 1'b0) bad++;
    check(bad == 0, "R2", {tag, " edges outside select"}, bad, 0);
    check(gotCnt == rd, "R7", {tag, " response count"}, gotCnt, rd);
    for (int k = 0; k < rd; k++)
      check(gotBytes[k] == rxBytes[k], "R7", {tag, " response byte"},
            gotBytes[k], rxBytes[k]);
    check(holdErr == 0, "R7", {tag, " response hold violations"}, holdErr, 0);
    check(hpErr == 0, "R10", {tag, " high-phase length errors"}, hpErr, 0);
    check(stallErr == 0, "R11", {tag, " clock during stall"}, stallErr, 0);
    idleCnt = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (!busy && csN && !sclk && sdoEn) idleCnt++;
    end
    check(idleCnt == 12, "R12", {tag, " stays idle after completion"}, idleCnt, 12);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(csN == 1'b1, "R1", "reset csN", csN, 1);
    check(sclk == 1'b0, "R1", "reset sclk", sclk, 0);
    check(sdoEn == 1'b1, "R1", "reset sdoEn", sdoEn, 1);
    check(busy == 1'b0, "R1", "reset busy", busy, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(csN && !sclk && sdoEn && !busy, "R1", "idle after reset release",
          {csN, sclk, sdoEn, busy}, 4'b1010);
  endtask

  task automatic test_msb_basic();
    run_txn(2, 2, 3, 2, 1'b0, 0, 0, 1'b0, "R3 R4 msb-first");
  endtask

  task automatic test_lsb_order();
    run_txn(3, 1, 2, 1, 1'b1, 0, 0, 1'b0, "R4 lsb-first");
  endtask

  task automatic test_swap_zero();
    run_txn(1, 1, 0, 2, 1'b0, 0, 0, 1'b0, "R6 swap zero");
  endtask

  task automatic test_no_write();
    run_txn(0, 2, 4, 1, 1'b1, 0, 0, 1'b0, "R9 read only");
    check(capOe[0] == 1'b0, "R9", "first edge released", capOe[0], 0);
  endtask

  task automatic test_stalls();
    run_txn(2, 2, 1, 3, 1'b0, 7, 6, 1'b0, "R11 handshake stalls");
  endtask

  task automatic test_half_zero();
    run_txn(1, 1, 2, 0, 1'b1, 0, 0, 1'b0, "R10 half zero");
  endtask

  task automatic test_busy_start();
    run_txn(2, 1, 5, 4, 1'b0, 0, 0, 1'b1, "R12 start while busy");
  endtask

  initial begin
    test_reset();
    test_msb_basic();
    test_lsb_order();
    test_swap_zero();
    test_no_write();
    test_stalls();
    test_half_zero();
    test_busy_start();
    finish_run();
  end

endmodule